// File: doc/BRIEF.md
# Serial Latched-Driver Word Loader

This block sits on the host side of a chain of serial-input latched output drivers. It takes a 32-bit word over a valid/ready handshake and produces four wire-level signals for the driver: a serial data line, a shift clock, a latch strobe and an output enable. The word goes out most significant bit first. Bit 31 therefore ends up in the stage farthest from the input after the last of the 32 shift clocks. The strobe is then pulsed to copy the shifted word into the output latches.

Every edge of the serial waveform is placed by counting system clock cycles. Setup and hold around the shift clock, the shift clock's high and low widths, the data bit width, the spacing from the last shift clock to the strobe, and the strobe width are all parameters given in nanoseconds. Each one is converted to whole system cycles by rounding up, with a floor of one cycle.

A per-word bypass flag is sampled when the word is accepted. It selects a mode in which the strobe stays high for the whole transfer, so the latches simply follow the shift stages. In that mode the output enable is held low while the word is shifting and returns high when the strobe falls. When the transfer finishes, a one-cycle done pulse is raised and the block is ready again.

Top module: `serial_driver_loader`

## Requirements
- R1: `ser_data_o` shows bit 31 of the accepted word from the cycle after acceptance. It moves to the next lower bit only in the same cycle as a falling edge of `ser_clk_o`, and it never changes while `ser_clk_o` is high. After the transfer it keeps bit 0 until the next word is accepted.
- R2: Each bit holds `ser_clk_o` low for LOW_C cycles and then high for HIGH_C cycles, where c(x) = max(1, ceil(x / CLK_PERIOD_NS)). LOW_C = max(c(SETUP_NS), c(CLK_LOW_NS), c(DATA_NS) - c(HIGH)), with the last term counting only when it is positive. HIGH_C = max(c(HOLD_NS), c(CLK_HIGH_NS)). With the default values both are 15 cycles.
- R3: Each accepted word produces exactly WORD_W rising edges of `ser_clk_o`.
- R4: The last falling edge of `ser_clk_o` is followed by GAP_C low cycles before the strobe phase starts, where GAP_C = max(1, c(CLK_TO_STB_NS) - HIGH_C). This places at least c(CLK_TO_STB_NS) cycles between the last rising edge and the strobe.
- R5: In normal mode, `latch_o` is high for exactly c(STB_NS) cycles after the gap and low at all other times. In bypass mode, it is high from the cycle after acceptance until the end of that same strobe window.
- R6: In normal mode, `out_en_o` stays high. In bypass mode, it goes low from the cycle after acceptance and returns high in the same cycle that `latch_o` falls.
- R7: `ready_o` is high only while idle. A word is taken when `valid_i` and `ready_o` are both high at a clock edge. `valid_i`, `word_i` and `bypass_i` have no effect while a transfer is running.
- R8: `done_o` is high for exactly one cycle, the cycle in which `latch_o` has just fallen. `ready_o` rises the cycle after.
- R9: After reset, `ser_clk_o`, `latch_o`, `ser_data_o` and `done_o` are low, and `out_en_o` and `ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | WORD_W | Word to send |
| valid_i | input | 1 | Word offered |
| bypass_i | input | 1 | Keep strobe high and outputs disabled during this transfer |
| ready_o | output | 1 | Idle, can take a word |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| ser_data_o | output | 1 | Serial data to the driver |
| ser_clk_o | output | 1 | Shift clock to the driver |
| latch_o | output | 1 | Latch strobe to the driver |
| out_en_o | output | 1 | Output enable to the driver, high enables |

## Verification
The hardest cases to reach from the ports are words offered while the block is busy, and words arriving in the same cycle that `ready_o` returns. The bench holds `valid_i` high for the whole of every transfer, with an inverted word and the opposite bypass flag, to show these are ignored. It also queues some words with no idle gap, so that acceptance lands in the first ready cycle. Normal and bypass transfers are interleaved, so that the enable and strobe have to switch modes between adjacent words.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_GAP, ST_STB, ST_DONE
  } sdl_state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdl_timer.sv
module sdl_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= word_i;
    else if (shift_i)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/serial_driver_loader.sv
module serial_driver_loader
  import sdl_pkg::*;
#(
  parameter int unsigned WORD_W        = 32,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SETUP_NS      = 75,
  parameter int unsigned HOLD_NS       = 75,
  parameter int unsigned CLK_HIGH_NS   = 150,
  parameter int unsigned CLK_LOW_NS    = 150,
  parameter int unsigned DATA_NS       = 150,
  parameter int unsigned CLK_TO_STB_NS = 300,
  parameter int unsigned STB_NS        = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              bypass_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              ser_data_o,
  output logic              ser_clk_o,
  output logic              latch_o,
  output logic              out_en_o
);
  localparam int unsigned HIGH_C = umax(ns2cyc(HOLD_NS, CLK_PERIOD_NS),
                                        ns2cyc(CLK_HIGH_NS, CLK_PERIOD_NS));
  localparam int unsigned DATA_C = ns2cyc(DATA_NS, CLK_PERIOD_NS);
  localparam int unsigned DATA_REM = (DATA_C > HIGH_C) ? DATA_C - HIGH_C : 1;
  localparam int unsigned LOW_C  = umax(umax(ns2cyc(SETUP_NS, CLK_PERIOD_NS),
                                             ns2cyc(CLK_LOW_NS, CLK_PERIOD_NS)), DATA_REM);
  localparam int unsigned C2S_C  = ns2cyc(CLK_TO_STB_NS, CLK_PERIOD_NS);
  localparam int unsigned GAP_C  = (C2S_C > HIGH_C) ? C2S_C - HIGH_C : 1;
  localparam int unsigned STB_C  = ns2cyc(STB_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_C  = umax(umax(LOW_C, HIGH_C), umax(GAP_C, STB_C));
  localparam int unsigned CW     = $clog2(MAX_C + 1);
  localparam int unsigned BW     = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  sdl_state_e st_q, st_d;
  logic sclk_q, sclk_d, latch_q, latch_d, oe_q, oe_d;
  logic [BW-1:0] bit_q, bit_d;
  logic tmr_load, tmr_zero, sh_load, sh_shift;
  logic [CW-1:0] tmr_val;

  sdl_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sdl_shifter #(.W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .word_i  (word_i),
    .shift_i (sh_shift),
    .msb_o   (ser_data_o)
  );

  always_comb begin
    st_d     = st_q;
    sclk_d   = sclk_q;
    latch_d  = latch_q;
    oe_d     = oe_q;
    bit_d    = bit_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (valid_i) begin
        st_d     = ST_LOW;
        tmr_load = 1'b1;
        tmr_val  = CW'(LOW_C - 1);
        sh_load  = 1'b1;
        oe_d     = !bypass_i;
        latch_d  = bypass_i;  // bypass: latches follow the shift stages
        bit_d    = '0;
      end
      ST_LOW: if (tmr_zero) begin
        st_d     = ST_HIGH;
        sclk_d   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CW'(HIGH_C - 1);
      end
      ST_HIGH: if (tmr_zero) begin
        sclk_d   = 1'b0;
        tmr_load = 1'b1;
        if (bit_q == BW'(WORD_W - 1)) begin
          st_d    = ST_GAP;
          tmr_val = CW'(GAP_C - 1);
        end else begin
          st_d     = ST_LOW;
          tmr_val  = CW'(LOW_C - 1);
          sh_shift = 1'b1;
          bit_d    = bit_q + 1'b1;
        end
      end
      ST_GAP: if (tmr_zero) begin
        st_d     = ST_STB;
        latch_d  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CW'(STB_C - 1);
      end
      ST_STB: if (tmr_zero) begin
        st_d    = ST_DONE;
        latch_d = 1'b0;
        oe_d    = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      oe_q    <= 1'b1;
      bit_q   <= '0;
    end else begin
      st_q    <= st_d;
      sclk_q  <= sclk_d;
      latch_q <= latch_d;
      oe_q    <= oe_d;
      bit_q   <= bit_d;
    end
  end

  assign ser_clk_o = sclk_q;
  assign latch_o   = latch_q;
  assign out_en_o  = oe_q;
  assign ready_o   = (st_q == ST_IDLE);
  assign done_o    = (st_q == ST_DONE);
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker
  import sdl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned HOLD_NS       = 75,
  parameter int unsigned CLK_HIGH_NS   = 150
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic done_o,
  input logic ser_data_o,
  input logic ser_clk_o,
  input logic latch_o,
  input logic out_en_o
);
  localparam int unsigned HIGH_C = umax(ns2cyc(HOLD_NS, CLK_PERIOD_NS),
                                        ns2cyc(CLK_HIGH_NS, CLK_PERIOD_NS));
  logic [15:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run <= '0;
    else if (ser_clk_o) hi_run <= hi_run + 1'b1;
    else                hi_run <= '0;
  end

  p_data_stable_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_clk_o |-> $stable(ser_data_o));
  p_clk_high_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_clk_o) |-> (hi_run >= 16'(HIGH_C)));
  p_strobe_clk_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_o) |-> !ser_clk_o);
  p_oe_off_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o && ser_clk_o) |-> !out_en_o);
  p_ready_not_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && done_o));
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(latch_o) && !latch_o && out_en_o));
endmodule

bind serial_driver_loader sdl_checker #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .HOLD_NS(HOLD_NS), .CLK_HIGH_NS(CLK_HIGH_NS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .done_o(done_o),
  .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .latch_o(latch_o),
  .out_en_o(out_en_o)
);

// File: tb/tb_serial_driver_loader.sv
module tb_serial_driver_loader;
  localparam int W = 32;
  // expected phase lengths, 10 ns cycle: ceil of 150/75, 150, 300, 100 ns
  localparam int L = 15, H = 15, G = 30 - 15, S = 10;
  localparam int P = L + H;
  localparam int END = W * P + G + S;

  logic clk = 0, rst_ni = 0;
  logic [W-1:0] word_i = '0;
  logic valid_i = 0, bypass_i = 0;
  logic ready_o, done_o, ser_data_o, ser_clk_o, latch_o, out_en_o;

  always #5 clk = ~clk;

  serial_driver_loader dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .valid_i(valid_i),
    .bypass_i(bypass_i), .ready_o(ready_o), .done_o(done_o),
    .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .latch_o(latch_o),
    .out_en_o(out_en_o)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // stimulus: {bypass, word}, idle gap before offer
  logic [W:0] items[$];
  int gaps[$];
  int mk = -1;
  logic [W-1:0] m_word = '0;
  logic m_byp = 0, last_data = 0, prev_clk = 0;
  int rises = 0, gap_cnt = 0, cyc = 0, tail = 0;

  initial begin
    items.push_back({1'b0, 32'hA5A5_0F0F}); gaps.push_back(3);
    items.push_back({1'b1, 32'hFFFF_FFFF}); gaps.push_back(0);
    items.push_back({1'b0, 32'h0000_0001}); gaps.push_back(0);
    items.push_back({1'b1, 32'h8000_0000}); gaps.push_back(5);
    items.push_back({1'b0, 32'h1234_5678}); gaps.push_back(0);
    gap_cnt = gaps[0];

    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 clk", ser_clk_o, 0);   chk("R9 latch", latch_o, 0);
    chk("R9 data", ser_data_o, 0); chk("R9 done", done_o, 0);
    chk("R9 oe", out_en_o, 1);     chk("R9 ready", ready_o, 1);
    rst_ni = 1;

    forever begin
      @(negedge clk);
      cyc++;
      // expected outputs for model state
      begin
        logic e_clk, e_dat, e_stb, e_oe, e_rdy, e_done;
        e_clk = 0; e_dat = last_data; e_stb = 0; e_oe = 1; e_rdy = 0; e_done = 0;
        if (mk < 0) e_rdy = 1;
        else if (mk < W * P) begin
          e_clk = (mk % P) >= L; e_dat = m_word[W - 1 - mk / P];
          e_stb = m_byp; e_oe = !m_byp;
        end else if (mk < W * P + G) begin
          e_dat = m_word[0]; e_stb = m_byp; e_oe = !m_byp;
        end else if (mk < END) begin
          e_dat = m_word[0]; e_stb = 1; e_oe = !m_byp;
        end else begin
          e_dat = m_word[0]; e_done = 1;
        end
        chk("R1 data", ser_data_o, e_dat);
        chk("R2 clk", ser_clk_o, e_clk);
        chk("R4/R5 latch", latch_o, e_stb);
        chk("R6 oe", out_en_o, e_oe);
        chk("R7 ready", ready_o, e_rdy);
        chk("R8 done", done_o, e_done);
        if (ser_clk_o && !prev_clk) rises++;
        prev_clk = ser_clk_o;
        if (done_o) begin
          n_cmp++;  // R3: WORD_W rising edges per word
          if (rises != W) begin
            n_bad++;
            $display("FAIL R3 rises actual=%0d expected=%0d", rises, W);
          end
        end
      end
      // drive inputs for the next edge and advance the model
      if (mk >= 0) begin
        valid_i = 1; word_i = ~m_word; bypass_i = !m_byp;  // ignored (R7)
        if (mk == END) begin
          mk = -1; last_data = m_word[0];
        end else mk++;
        valid_i = (mk >= 0);  // no junk on the ready cycle itself
      end else if (items.size() != 0 && gap_cnt > 0) begin
        valid_i = 0; gap_cnt--;
      end else if (items.size() != 0) begin
        valid_i = 1; word_i = items[0][W-1:0]; bypass_i = items[0][W];
        m_word = items[0][W-1:0]; m_byp = items[0][W];
        void'(items.pop_front()); void'(gaps.pop_front());
        if (gaps.size() != 0) gap_cnt = gaps[0];
        mk = 0; rises = 0;
      end else begin
        valid_i = 0;
        tail++;
        if (tail > 5) break;
      end
      if (cyc > 20000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<=20000", cyc);
        break;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule